// File: doc/BRIEF.md
# Multiplexed GPIO Port Controller

An eight-pin bidirectional general-purpose port. Each pin has a direction bit and an output-latch bit, and a software-readable input path through a two-stage synchroniser. Software reaches four byte registers over a simple read/write bus. Read data is registered and appears one cycle after the read strobe.

Every pin belongs at any moment either to plain I/O or to one overriding function. The functions are a display common drive, a display bias line, the display segment drive, or a PWM output. Ownership is decoded from pin-level inputs: a 2-bit common-multiplex code, the internal-bias-ladder select, the segment enable and two PWM routing bits. When a function owns a pin, the function's drive value and enable reach the pad, the weak pull-up is held off and the pin reads back as 0. The display controller, bias ladder and PWM generators live outside the block and show up only as these inputs.

Register map (`bus_addr`): 0 = port data (write: latch, read: synchronised pins), 1 = latch, 2 = direction, 3 = configuration (bit 0 = global pull-up enable, bit 1 = pin 7 open-drain enable, other bits read 0).

Top module: `gpio_mux_port`

## Requirements
- R1: After reset, direction reads 0xFF (1 = input), latch reads 0x00, configuration reads 0x00 and `pad_pu` is 0. Every I/O-owned pin has `pad_oe` = 0.
- R2: An I/O-owned pin drives `pad_out` = latch bit and `pad_oe` = NOT direction bit.
- R3: `pad_pu` bits can be 1 only while configuration bit 0 is set. Clearing the bit turns every pull-up off.
- R4: The pull-up of an I/O pin whose direction bit is 0 is off, even with the global enable set.
- R5: Common code c (0..3) gives pins 3..3+c to the common drives, and `com_drv[k]` drives pin 3+k with the enable on. So 0 frees pins 6,5,4; 1 frees 6,5; 2 frees 6; 3 frees none.
- R6: While `bias_int` = 0, pins 2..0 are bias lines: `pad_oe` = 0, `pad_out` = 0 and no pull-up.
- R7: While `seg7_en` = 1, pin 7 follows `seg7_drv` with its enable on.
- R8: With `seg7_en` = 0 and `pin7_remap_n` = 0, pin 7 carries `pwm2_drv`. With configuration bit 1 set, it drives 0 with the enable on when the data is 0 and releases (enable off) when the data is 1.
- R9: With `pwm13_home` = 1, `pwm13_drv` bits 0..3 drive pins 6, 5, 2 and 1. Display claims take priority. With `pwm13_home` = 0 those pins return to I/O.
- R10: A write to address 0 or to address 1 loads the latch, and the result reads back from address 1.
- R11: A read of address 0 returns the pad inputs after two synchroniser stages, ANDed with the I/O-ownership mask. A pad change made in the same cycle as the read strobe is not yet visible.
- R12: A function-owned pin has its pull-up off and reads as 0 through address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| com_mux | input | 2 | Display common-multiplex code |
| bias_int | input | 1 | 1 = bias from internal ladder, pins 2..0 free |
| seg7_en | input | 1 | Segment drive claims pin 7 |
| pin7_remap_n | input | 1 | 0 = PWM channel 2 output placed on pin 7 |
| pwm13_home | input | 1 | 1 = PWM channel 1/3 B,C outputs on this port |
| com_drv | input | 4 | Common drive levels for pins 3..6 |
| seg7_drv | input | 1 | Segment drive level for pin 7 |
| pwm13_drv | input | 4 | {ch3 C, ch3 B, ch1 C, ch1 B} levels |
| pwm2_drv | input | 1 | PWM channel 2 level |
| pad_in | input | 8 | Pad input levels |
| pad_out | output | 8 | Pad output levels |
| pad_oe | output | 8 | Pad output enables |
| pad_pu | output | 8 | Weak pull-up enables |

## Verification
The hardest case is the open-drain mode on pin 7. It needs the segment released, the PWM remap cleared and configuration bit 1 written, all at once, and the output enable must then follow the inverse of the PWM level. The bench sets these up in sequence and toggles `pwm2_drv` with the other pins held. It checks the pin's drive, enable and pull-up for each level. A second check with the mode bit clear confirms normal push-pull behaviour.

// File: rtl/gpio_mux_pkg.sv
`timescale 1ns/1ps
package gpio_mux_pkg;
    localparam int PORT_W      = 8;
    localparam int SYNC_STAGES = 2;
    localparam int COM_LO      = 3;
    localparam int COM_N       = 4;
    localparam int BIAS_N      = 3;
    localparam int SEG_PIN     = 7;
    localparam int PWM1B_PIN   = 6;
    localparam int PWM1C_PIN   = 5;
    localparam int PWM3B_PIN   = 2;
    localparam int PWM3C_PIN   = 1;
    localparam int CFG_PU_BIT  = 0;
    localparam int CFG_OD_BIT  = 1;

    localparam logic [1:0] ADDR_PORT  = 2'd0;
    localparam logic [1:0] ADDR_LATCH = 2'd1;
    localparam logic [1:0] ADDR_DIR   = 2'd2;
    localparam logic [1:0] ADDR_CFG   = 2'd3;

    typedef enum logic [2:0] {
        OWN_IO,
        OWN_COM,
        OWN_BIAS,
        OWN_SEG,
        OWN_PWM
    } pin_own_e;

    typedef struct packed {
        logic [PORT_W-1:0] latch;
        logic [PORT_W-1:0] dir;
        logic              pu_gen;
        logic              od_en;
        logic [PORT_W-1:0] rdata;
    } port_regs_t;
endpackage

// File: rtl/gpio_mux_sync.sv
`timescale 1ns/1ps
module gpio_mux_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [STAGES-1:0][W-1:0] st_d, st_q;

    always_comb begin
        st_d[0] = din;
        for (int k = 1; k < STAGES; k++) begin
            st_d[k] = st_q[k-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dout = st_q[STAGES-1];
endmodule

// File: rtl/gpio_mux_claim.sv
`timescale 1ns/1ps
module gpio_mux_claim
    import gpio_mux_pkg::*;
#(
    parameter int W = PORT_W
) (
    input  logic [1:0] com_mux,
    input  logic       bias_int,
    input  logic       seg7_en,
    input  logic       pin7_remap_n,
    input  logic       pwm13_home,
    output pin_own_e   own [W]
);
    for (genvar i = 0; i < W; i++) begin : g_pin
        pin_own_e own_l;

        always_comb begin
            own_l = OWN_IO;
            if (i == SEG_PIN) begin
                if (seg7_en)            own_l = OWN_SEG;
                else if (!pin7_remap_n) own_l = OWN_PWM;
            end else if (i >= COM_LO && i < COM_LO + COM_N) begin
                if ((i - COM_LO) <= int'(com_mux)) begin
                    own_l = OWN_COM;
                end else if (pwm13_home && (i == PWM1B_PIN || i == PWM1C_PIN)) begin
                    own_l = OWN_PWM;
                end
            end else if (i < BIAS_N) begin
                if (!bias_int) begin
                    own_l = OWN_BIAS;
                end else if (pwm13_home && (i == PWM3B_PIN || i == PWM3C_PIN)) begin
                    own_l = OWN_PWM;
                end
            end
        end

        assign own[i] = own_l;
    end
endmodule

// File: rtl/gpio_mux_drive.sv
`timescale 1ns/1ps
module gpio_mux_drive
    import gpio_mux_pkg::*;
#(
    parameter int W = PORT_W
) (
    input  pin_own_e         own [W],
    input  logic [W-1:0]     latch,
    input  logic [W-1:0]     dir,
    input  logic             pu_gen,
    input  logic             od_en,
    input  logic [COM_N-1:0] com_drv,
    input  logic             seg7_drv,
    input  logic [3:0]       pwm13_drv,
    input  logic             pwm2_drv,
    output logic [W-1:0]     pad_out,
    output logic [W-1:0]     pad_oe,
    output logic [W-1:0]     pad_pu,
    output logic [W-1:0]     io_mask
);
    logic [W-1:0] com_vec;
    logic [W-1:0] pwm_vec;

    always_comb begin
        com_vec                  = '0;
        com_vec[COM_LO +: COM_N] = com_drv;
        pwm_vec                  = '0;
        pwm_vec[PWM1B_PIN]       = pwm13_drv[0];
        pwm_vec[PWM1C_PIN]       = pwm13_drv[1];
        pwm_vec[PWM3B_PIN]       = pwm13_drv[2];
        pwm_vec[PWM3C_PIN]       = pwm13_drv[3];
        pwm_vec[SEG_PIN]         = pwm2_drv;
    end

    for (genvar i = 0; i < W; i++) begin : g_pin
        logic o_l, e_l, p_l, m_l;

        always_comb begin
            o_l = 1'b0;
            e_l = 1'b0;
            p_l = 1'b0;
            m_l = 1'b0;
            unique case (own[i])
                OWN_IO: begin
                    o_l = latch[i];
                    e_l = ~dir[i];
                    p_l = pu_gen & dir[i];
                    m_l = 1'b1;
                end
                OWN_COM: begin
                    o_l = com_vec[i];
                    e_l = 1'b1;
                end
                OWN_SEG: begin
                    o_l = seg7_drv;
                    e_l = 1'b1;
                end
                OWN_PWM: begin
                    if (i == SEG_PIN && od_en) begin
                        o_l = 1'b0;
                        e_l = ~pwm_vec[i];
                    end else begin
                        o_l = pwm_vec[i];
                        e_l = 1'b1;
                    end
                end
                default: begin
                    o_l = 1'b0;
                    e_l = 1'b0;
                end
            endcase
        end

        assign pad_out[i] = o_l;
        assign pad_oe[i]  = e_l;
        assign pad_pu[i]  = p_l;
        assign io_mask[i] = m_l;
    end
endmodule

// File: rtl/gpio_mux_regs.sv
`timescale 1ns/1ps
module gpio_mux_regs
    import gpio_mux_pkg::*;
#(
    parameter int W = PORT_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         bus_wr,
    input  logic         bus_rd,
    input  logic [1:0]   bus_addr,
    input  logic [W-1:0] bus_wdata,
    input  logic [W-1:0] port_in,
    output logic [W-1:0] latch,
    output logic [W-1:0] dir,
    output logic         pu_gen,
    output logic         od_en,
    output logic [W-1:0] rdata
);
    port_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (bus_wr) begin
            unique case (bus_addr)
                ADDR_PORT, ADDR_LATCH: r_d.latch = bus_wdata;
                ADDR_DIR:              r_d.dir   = bus_wdata;
                default: begin
                    r_d.pu_gen = bus_wdata[CFG_PU_BIT];
                    r_d.od_en  = bus_wdata[CFG_OD_BIT];
                end
            endcase
        end
        if (bus_rd) begin
            unique case (bus_addr)
                ADDR_PORT:  r_d.rdata = port_in;
                ADDR_LATCH: r_d.rdata = r_q.latch;
                ADDR_DIR:   r_d.rdata = r_q.dir;
                default: begin
                    r_d.rdata             = '0;
                    r_d.rdata[CFG_PU_BIT] = r_q.pu_gen;
                    r_d.rdata[CFG_OD_BIT] = r_q.od_en;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.latch  <= '0;
            r_q.dir    <= '1;
            r_q.pu_gen <= 1'b0;
            r_q.od_en  <= 1'b0;
            r_q.rdata  <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign latch  = r_q.latch;
    assign dir    = r_q.dir;
    assign pu_gen = r_q.pu_gen;
    assign od_en  = r_q.od_en;
    assign rdata  = r_q.rdata;
endmodule

// File: rtl/gpio_mux_port.sv
`timescale 1ns/1ps
module gpio_mux_port
    import gpio_mux_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [1:0]        bus_addr,
    input  logic [PORT_W-1:0] bus_wdata,
    output logic [PORT_W-1:0] bus_rdata,
    input  logic [1:0]        com_mux,
    input  logic              bias_int,
    input  logic              seg7_en,
    input  logic              pin7_remap_n,
    input  logic              pwm13_home,
    input  logic [COM_N-1:0]  com_drv,
    input  logic              seg7_drv,
    input  logic [3:0]        pwm13_drv,
    input  logic              pwm2_drv,
    input  logic [PORT_W-1:0] pad_in,
    output logic [PORT_W-1:0] pad_out,
    output logic [PORT_W-1:0] pad_oe,
    output logic [PORT_W-1:0] pad_pu
);
    pin_own_e          own_w [PORT_W];
    logic [PORT_W-1:0] latch_w, dir_w, io_mask_w, sync_w, port_in_w;
    logic              pu_gen_w, od_en_w;

    gpio_mux_sync #(.W(PORT_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (pad_in),
        .dout  (sync_w)
    );

    gpio_mux_claim #(.W(PORT_W)) u_claim (
        .com_mux      (com_mux),
        .bias_int     (bias_int),
        .seg7_en      (seg7_en),
        .pin7_remap_n (pin7_remap_n),
        .pwm13_home   (pwm13_home),
        .own          (own_w)
    );

    gpio_mux_drive #(.W(PORT_W)) u_drive (
        .own       (own_w),
        .latch     (latch_w),
        .dir       (dir_w),
        .pu_gen    (pu_gen_w),
        .od_en     (od_en_w),
        .com_drv   (com_drv),
        .seg7_drv  (seg7_drv),
        .pwm13_drv (pwm13_drv),
        .pwm2_drv  (pwm2_drv),
        .pad_out   (pad_out),
        .pad_oe    (pad_oe),
        .pad_pu    (pad_pu),
        .io_mask   (io_mask_w)
    );

    assign port_in_w = sync_w & io_mask_w;

    gpio_mux_regs #(.W(PORT_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .port_in   (port_in_w),
        .latch     (latch_w),
        .dir       (dir_w),
        .pu_gen    (pu_gen_w),
        .od_en     (od_en_w),
        .rdata     (bus_rdata)
    );
endmodule

// File: rtl/gpio_mux_port_chk.sv
`timescale 1ns/1ps
module gpio_mux_port_chk
    import gpio_mux_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [1:0]        bus_addr,
    input logic [PORT_W-1:0] bus_wdata,
    input logic [1:0]        com_mux,
    input logic              bias_int,
    input logic              seg7_en,
    input logic              pin7_remap_n,
    input logic              seg7_drv,
    input logic              pwm2_drv,
    input logic [PORT_W-1:0] pad_out,
    input logic [PORT_W-1:0] pad_oe,
    input logic [PORT_W-1:0] pad_pu,
    input logic [PORT_W-1:0] dir,
    input logic [PORT_W-1:0] latch,
    input logic              pu_gen,
    input logic              od_en
);
    a_r1_reset_dir_inputs: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (dir == '1 && latch == '0 && !pu_gen));

    a_r3_pu_needs_global: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_pu != '0) |-> pu_gen);

    a_r4_pu_off_on_output: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_pu & ~dir) == '0);

    a_r5_all_commons_drive: assert property (@(posedge clk) disable iff (!rst_n)
        (com_mux == 2'b11) |-> (pad_oe[COM_LO +: COM_N] == '1 && pad_pu[COM_LO +: COM_N] == '0));

    a_r6_bias_released: assert property (@(posedge clk) disable iff (!rst_n)
        !bias_int |-> (pad_oe[BIAS_N-1:0] == '0 && pad_out[BIAS_N-1:0] == '0 && pad_pu[BIAS_N-1:0] == '0));

    a_r7_segment_drive: assert property (@(posedge clk) disable iff (!rst_n)
        seg7_en |-> (pad_oe[SEG_PIN] && pad_out[SEG_PIN] == seg7_drv));

    a_r8_open_drain: assert property (@(posedge clk) disable iff (!rst_n)
        (!seg7_en && !pin7_remap_n && od_en) |-> (!pad_out[SEG_PIN] && pad_oe[SEG_PIN] == !pwm2_drv));

    a_r10_latch_write: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && (bus_addr == ADDR_PORT || bus_addr == ADDR_LATCH)) |=> (latch == $past(bus_wdata)));
endmodule

bind gpio_mux_port gpio_mux_port_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_wr       (bus_wr),
    .bus_addr     (bus_addr),
    .bus_wdata    (bus_wdata),
    .com_mux      (com_mux),
    .bias_int     (bias_int),
    .seg7_en      (seg7_en),
    .pin7_remap_n (pin7_remap_n),
    .seg7_drv     (seg7_drv),
    .pwm2_drv     (pwm2_drv),
    .pad_out      (pad_out),
    .pad_oe       (pad_oe),
    .pad_pu       (pad_pu),
    .dir          (dir_w),
    .latch        (latch_w),
    .pu_gen       (pu_gen_w),
    .od_en        (od_en_w)
);

// File: tb/gpio_mux_port_tb.sv
`timescale 1ns/1ps
module gpio_mux_port_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic [1:0] com_mux = 2'b00;
    logic       bias_int = 1'b1, seg7_en = 1'b0, pin7_remap_n = 1'b1, pwm13_home = 1'b0;
    logic [3:0] com_drv = 4'h0, pwm13_drv = 4'h0;
    logic       seg7_drv = 1'b0, pwm2_drv = 1'b0;
    logic [7:0] pad_in = 8'h00;
    logic [7:0] pad_out, pad_oe, pad_pu;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #10 clk = ~clk;

    gpio_mux_port u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .com_mux(com_mux), .bias_int(bias_int), .seg7_en(seg7_en),
        .pin7_remap_n(pin7_remap_n), .pwm13_home(pwm13_home),
        .com_drv(com_drv), .seg7_drv(seg7_drv), .pwm13_drv(pwm13_drv),
        .pwm2_drv(pwm2_drv), .pad_in(pad_in), .pad_out(pad_out),
        .pad_oe(pad_oe), .pad_pu(pad_pu)
    );

    // {com_mux[1:0], bias_int, seg7_en, pin7_remap_n, pwm13_home, expected I/O mask[7:0]}
    localparam int NVEC = 10;
    localparam logic [13:0] VEC [NVEC] = '{
        {2'b00, 1'b1, 1'b0, 1'b1, 1'b0, 8'hF7},
        {2'b01, 1'b1, 1'b0, 1'b1, 1'b0, 8'hE7},
        {2'b10, 1'b1, 1'b0, 1'b1, 1'b0, 8'hC7},
        {2'b11, 1'b1, 1'b0, 1'b1, 1'b0, 8'h87},
        {2'b00, 1'b0, 1'b0, 1'b1, 1'b0, 8'hF0},
        {2'b00, 1'b1, 1'b1, 1'b1, 1'b0, 8'h77},
        {2'b00, 1'b1, 1'b0, 1'b0, 1'b0, 8'h77},
        {2'b00, 1'b1, 1'b0, 1'b1, 1'b1, 8'h91},
        {2'b10, 1'b1, 1'b0, 1'b1, 1'b1, 8'h81},
        {2'b11, 1'b0, 1'b1, 1'b0, 1'b1, 8'h00}
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic settle();
        @(negedge clk);
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            summary();
        end
    end

    initial begin
        logic [7:0] rd;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        settle();
        check("R1 pad_pu after reset", pad_pu, 8'h00);
        check("R1 pad_oe after reset (only pin3 common)", pad_oe, 8'h08);
        bus_read(2'd2, rd); check("R1 direction reset", rd, 8'hFF);
        bus_read(2'd1, rd); check("R1 latch reset", rd, 8'h00);
        bus_read(2'd3, rd); check("R1 config reset", rd, 8'h00);

        // R5 R6 R7 R9 ownership table: all outputs, latch ones, function drivers zero
        bus_write(2'd2, 8'h00);
        bus_write(2'd1, 8'hFF);
        for (int k = 0; k < NVEC; k++) begin
            @(negedge clk);
            {com_mux, bias_int, seg7_en, pin7_remap_n, pwm13_home} = VEC[k][13:8];
            settle();
            check($sformatf("R5 R6 R7 R9 ownership vector %0d", k), pad_out, VEC[k][7:0]);
        end
        @(negedge clk);
        com_mux = 2'b00; bias_int = 1'b1; seg7_en = 1'b0; pin7_remap_n = 1'b1; pwm13_home = 1'b0;

        // R2 plain I/O drive
        bus_write(2'd0, 8'h5A);
        settle();
        check("R2 pad_out from latch", pad_out, 8'h52);
        check("R2 pad_oe all outputs", pad_oe, 8'hFF);
        bus_write(2'd2, 8'h0F);
        settle();
        check("R2 pad_oe follows direction", pad_oe, 8'hF8);

        // R3 R4 pull-ups
        check("R3 pull-ups off with global clear", pad_pu, 8'h00);
        bus_write(2'd3, 8'h01);
        settle();
        check("R4 pull-ups only on input pins", pad_pu, 8'h07);
        bus_write(2'd2, 8'hFF);
        settle();
        check("R3 pull-ups on all I/O inputs", pad_pu, 8'hF7);

        // R12 claimed pins
        @(negedge clk); com_mux = 2'b11; pad_in = 8'hFF;
        settle();
        check("R12 commons drop pull-up", pad_pu, 8'h87);
        @(negedge clk); bias_int = 1'b0;
        settle();
        check("R12 bias drops pull-up", pad_pu, 8'h80);
        repeat (3) @(negedge clk);
        bus_read(2'd0, rd); check("R12 claimed pins read zero", rd, 8'h80);
        @(negedge clk); com_mux = 2'b00; bias_int = 1'b1;

        // R11 synchronised read path
        @(negedge clk); pad_in = 8'h3C;
        repeat (3) @(negedge clk);
        bus_read(2'd0, rd); check("R11 port read masked", rd, 8'h34);
        @(negedge clk);
        pad_in = 8'hC3; bus_rd = 1'b1; bus_addr = 2'd0;
        @(negedge clk);
        bus_rd = 1'b0;
        check("R11 same-cycle change not visible", bus_rdata, 8'h34);
        repeat (3) @(negedge clk);
        bus_read(2'd0, rd); check("R11 port read after sync", rd, 8'hC3);

        // R10 both addresses load the latch
        bus_write(2'd1, 8'h00);
        bus_read(2'd1, rd); check("R10 latch via addr1", rd, 8'h00);
        bus_write(2'd0, 8'hA5);
        bus_read(2'd1, rd); check("R10 latch via addr0", rd, 8'hA5);

        // R8 pin 7 PWM and open drain
        @(negedge clk); pin7_remap_n = 1'b0; pwm2_drv = 1'b1;
        bus_write(2'd3, 8'h01);
        settle();
        check("R8 push-pull out", {7'b0, pad_out[7]}, 8'h01);
        check("R8 push-pull oe", {7'b0, pad_oe[7]}, 8'h01);
        bus_write(2'd3, 8'h03);
        settle();
        check("R8 open drain high releases", {7'b0, pad_oe[7]}, 8'h00);
        check("R8 open drain high out", {7'b0, pad_out[7]}, 8'h00);
        check("R12 pin7 pwm no pull-up", {7'b0, pad_pu[7]}, 8'h00);
        @(negedge clk); pwm2_drv = 1'b0;
        settle();
        check("R8 open drain low drives", {7'b0, pad_oe[7]}, 8'h01);
        check("R8 open drain low out", {7'b0, pad_out[7]}, 8'h00);

        // R7 segment priority
        @(negedge clk); seg7_en = 1'b1; seg7_drv = 1'b1;
        settle();
        check("R7 segment high", {6'b0, pad_oe[7], pad_out[7]}, 8'h03);
        @(negedge clk); seg7_drv = 1'b0;
        settle();
        check("R7 segment low", {6'b0, pad_oe[7], pad_out[7]}, 8'h02);
        @(negedge clk); seg7_en = 1'b0; pin7_remap_n = 1'b1;

        // R9 PWM channel 1/3 values
        @(negedge clk); pwm13_home = 1'b1; pwm13_drv = 4'b0101;
        settle();
        check("R9 pwm values 0101", pad_out & 8'h66, 8'h44);
        @(negedge clk); pwm13_drv = 4'b1010;
        settle();
        check("R9 pwm values 1010", pad_out & 8'h66, 8'h22);
        @(negedge clk); pwm13_home = 1'b0;
        settle();
        check("R9 moved away returns inputs", pad_oe & 8'h66, 8'h00);

        // R5 common drive values
        @(negedge clk); com_mux = 2'b11; com_drv = 4'b1001;
        settle();
        check("R5 common levels", (pad_out >> 3) & 8'h0F, 8'h09);
        @(negedge clk); com_mux = 2'b00;

        // R1 reset in mid-run
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        settle();
        check("R1 pull-ups off after mid-run reset", pad_pu, 8'h00);
        bus_read(2'd2, rd); check("R1 direction after mid-run reset", rd, 8'hFF);
        bus_read(2'd3, rd); check("R1 config after mid-run reset", rd, 8'h00);

        done = 1'b1;
        summary();
    end
endmodule